// File: doc/BRIEF.md
# Control and Acknowledge Frame Parser

This block sits behind an Ethernet MAC on the receive side of a data-acquisition link. It takes frames one byte per accepted beat on a valid/last stream. The MAC supplies an error flag together with the final byte. The block checks the addressing and protocol header of each frame. It then sorts every surviving frame into one of two kinds.

An acknowledge frame becomes a one-cycle event. The event carries the acknowledged stream packet number, the repetition number used for loss handling, and the measured transmission delay. Any other code becomes a one-cycle command entry. The entry carries the command code, its sequence number and a 32-bit argument. The source address of the most recent accepted command is kept as the peer address, for use by the transmit side.

A frame that fails any check leaves no trace on the outputs. Nothing is issued before the final byte of a frame has been seen.

Top module: `ctl_ack_rx`

## Requirements
- R1: While reset is asserted and after its release, `ackValid` and `cmdValid` are low and `peerMac` is zero.
- R2: A frame whose code (bytes 16-17) is 0x0003 is an acknowledge frame. It raises `ackValid` for exactly one cycle, the cycle after its last byte. In that cycle `ackRepeat` holds bytes 18-19, `ackPacket` holds bytes 20-23 and `ackDelay` holds bytes 24-27. Each multi-byte field is taken with the first received byte as the most significant.
- R3: A frame with any other code is a command frame. It raises `cmdValid` for exactly one cycle, the cycle after its last byte. In that cycle `cmdCode` holds bytes 16-17, `cmdSeq` holds bytes 18-19 and `cmdArg` holds bytes 20-23, most significant byte first.
- R4: Bytes 0-5 are the destination address. A frame is accepted only if this address equals `localMac` (byte 0 = `localMac[47:40]`) or is all ones. A frame mixing bytes of both is dropped.
- R5: A frame is dropped unless bytes 12-13 are 0xFA, 0xDE and bytes 14-15 are 0x01, 0x00.
- R6: An acknowledge frame shorter than 28 bytes is dropped. A command frame shorter than 24 bytes is dropped. Exactly 28 and exactly 24 bytes are accepted.
- R7: A frame whose last byte carries `rxErr` high is dropped.
- R8: Bytes beyond the used fields, including frames longer than the byte counter range, do not affect the outputs. Idle cycles with `rxValid` low inside a frame do not affect the outputs.
- R9: `peerMac` takes bytes 6-11 of an accepted command frame, one cycle after its `cmdValid`. Acknowledge frames and dropped frames leave it unchanged.
- R10: At most one event per frame is issued, and never both kinds in one cycle. This holds for frames sent back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| localMac | input | 48 | Configured station address |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | Byte valid this cycle |
| rxLast | input | 1 | Final byte of the frame |
| rxErr | input | 1 | Frame error, meaningful with rxLast |
| ackValid | output | 1 | Acknowledge event strobe |
| ackRepeat | output | 16 | Repetition number of the acknowledge |
| ackPacket | output | 32 | Acknowledged packet number |
| ackDelay | output | 32 | Transmission delay value |
| cmdValid | output | 1 | Command entry strobe |
| cmdCode | output | 16 | Command code |
| cmdSeq | output | 16 | Command sequence number |
| cmdArg | output | 32 | Command argument |
| peerMac | output | 48 | Source address of the latest accepted command |

## Verification
The hardest situations to reach from the ports are frames that sit exactly on a decision edge. One is a destination address whose bytes are partly broadcast and partly local, so that each byte on its own passes one of the two tests. Another is a frame ending one byte before, or exactly at, the minimum length of its kind. The bench builds frames byte by byte from field values, so it can forge these directly. It also sends them back to back, with no idle cycle, so the next frame's first byte arrives in the same cycle as the previous frame's event. Idle gaps inside frames and frames longer than the counter range are mixed in. A behavioural model decodes every frame from the raw byte queue and is compared with the outputs on every clock.

// File: rtl/ctl_ack_rx_pkg.sv
package ctl_ack_rx_pkg;
  localparam int MAC_W = 48;
  localparam int MAC_BYTES = MAC_W / 8;
  localparam logic [15:0] ETHER_TYPE = 16'hFADE;
  localparam logic [15:0] PROTO_VER = 16'h0100;
  localparam logic [15:0] ACK_CODE = 16'h0003;
  // byte positions of the frame fields
  localparam int SRC_LO = MAC_BYTES;
  localparam int HDR_LO = 2 * MAC_BYTES;
  localparam int CODE_LO = HDR_LO + 4;
  localparam int F18_LO = CODE_LO + 2;
  localparam int F20_LO = F18_LO + 2;
  localparam int F24_LO = F20_LO + 4;
  localparam int CMD_BYTES = F24_LO;
  localparam int ACK_BYTES = F24_LO + 4;

  typedef struct packed {
    logic shSrc;
    logic shCode;
    logic shF18;
    logic shF20;
    logic shF24;
    logic emitCmd;
  } dpCtl_t;
endpackage

// File: rtl/ctl_ack_rx_dp.sv
module ctl_ack_rx_dp
  import ctl_ack_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       rxData,
  input  dpCtl_t           ctl,
  output logic [15:0]      codeField,
  output logic [15:0]      field18,
  output logic [31:0]      field20,
  output logic [31:0]      field24,
  output logic [MAC_W-1:0] peerMac
);
  logic [MAC_W-1:0] srcSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSh     <= '0;
      codeField <= '0;
      field18   <= '0;
      field20   <= '0;
      field24   <= '0;
      peerMac   <= '0;
    end else begin
      if (ctl.shSrc)   srcSh     <= {srcSh[MAC_W-9:0], rxData};
      if (ctl.shCode)  codeField <= {codeField[7:0], rxData};
      if (ctl.shF18)   field18   <= {field18[7:0], rxData};
      if (ctl.shF20)   field20   <= {field20[23:0], rxData};
      if (ctl.shF24)   field24   <= {field24[23:0], rxData};
      if (ctl.emitCmd) peerMac   <= srcSh;
    end
  end
endmodule

// File: rtl/ctl_ack_rx_ctrl.sv
module ctl_ack_rx_ctrl
  import ctl_ack_rx_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       rxData,
  input  logic             rxValid,
  input  logic             rxLast,
  input  logic             rxErr,
  input  logic [MAC_W-1:0] localMac,
  input  logic [15:0]      codeField,
  output dpCtl_t           ctl,
  output logic             ackValid,
  output logic             cmdValid
);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;
  localparam logic [IDX_W-1:0] ACK_LAST = IDX_W'(ACK_BYTES - 1);
  localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_BYTES - 1);
  localparam logic [31:0]      HDR_EXP  = {ETHER_TYPE, PROTO_VER};

  logic [IDX_W-1:0] idx;
  logic notLocal, notBcast, hdrBad;
  logic nNotLocal, nNotBcast, nHdrBad;
  logic [7:0] dstExp, hdrExp;
  logic inDst, inHdr, frameOk, isAck, goAck, goCmd;

  function automatic logic inSpan(input logic [IDX_W-1:0] i, input int lo, input int n);
    return (i >= IDX_W'(lo)) && (i <= IDX_W'(lo + n - 1));
  endfunction

  always_comb begin
    dstExp = '0;
    hdrExp = '0;
    for (int b = 0; b < MAC_BYTES; b++)
      if (idx == IDX_W'(b)) dstExp = localMac[8*(MAC_BYTES-1-b) +: 8];
    for (int b = 0; b < 4; b++)
      if (idx == IDX_W'(HDR_LO + b)) hdrExp = HDR_EXP[8*(3-b) +: 8];
    inDst = rxValid && inSpan(idx, 0, MAC_BYTES);
    inHdr = rxValid && inSpan(idx, HDR_LO, 4);
    nNotLocal = notLocal | (inDst && rxData != dstExp);
    nNotBcast = notBcast | (inDst && rxData != 8'hFF);
    nHdrBad   = hdrBad | (inHdr && rxData != hdrExp);

    ctl.shSrc   = rxValid && inSpan(idx, SRC_LO, MAC_BYTES);
    ctl.shCode  = rxValid && inSpan(idx, CODE_LO, 2);
    ctl.shF18   = rxValid && inSpan(idx, F18_LO, 2);
    ctl.shF20   = rxValid && inSpan(idx, F20_LO, 4);
    ctl.shF24   = rxValid && inSpan(idx, F24_LO, 4);
    ctl.emitCmd = cmdValid;

    // code bytes are complete whenever the length threshold is met
    frameOk = rxValid && rxLast && !rxErr && !(nNotLocal && nNotBcast) && !nHdrBad;
    isAck   = (codeField == ACK_CODE);
    goAck   = frameOk && isAck && (idx >= ACK_LAST);
    goCmd   = frameOk && !isAck && (idx >= CMD_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      notLocal <= 1'b0;
      notBcast <= 1'b0;
      hdrBad   <= 1'b0;
      ackValid <= 1'b0;
      cmdValid <= 1'b0;
    end else begin
      ackValid <= goAck;
      cmdValid <= goCmd;
      if (rxValid) begin
        if (rxLast) begin
          idx      <= '0;
          notLocal <= 1'b0;
          notBcast <= 1'b0;
          hdrBad   <= 1'b0;
        end else begin
          if (idx != IDX_MAX) idx <= idx + 1'b1;
          notLocal <= nNotLocal;
          notBcast <= nNotBcast;
          hdrBad   <= nHdrBad;
        end
      end
    end
  end
endmodule

// File: rtl/ctl_ack_rx.sv
module ctl_ack_rx
  import ctl_ack_rx_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [47:0] localMac,
  input  logic [7:0]  rxData,
  input  logic        rxValid,
  input  logic        rxLast,
  input  logic        rxErr,
  output logic        ackValid,
  output logic [15:0] ackRepeat,
  output logic [31:0] ackPacket,
  output logic [31:0] ackDelay,
  output logic        cmdValid,
  output logic [15:0] cmdCode,
  output logic [15:0] cmdSeq,
  output logic [31:0] cmdArg,
  output logic [47:0] peerMac
);
  dpCtl_t ctl;
  logic [15:0] codeField, field18;
  logic [31:0] field20, field24;

  ctl_ack_rx_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .rxLast(rxLast),
    .rxErr(rxErr), .localMac(localMac), .codeField(codeField), .ctl(ctl),
    .ackValid(ackValid), .cmdValid(cmdValid)
  );

  ctl_ack_rx_dp u_dp (
    .clk(clk), .rstN(rstN), .rxData(rxData), .ctl(ctl), .codeField(codeField),
    .field18(field18), .field20(field20), .field24(field24), .peerMac(peerMac)
  );

  assign ackRepeat = field18;
  assign ackPacket = field20;
  assign ackDelay  = field24;
  assign cmdCode   = codeField;
  assign cmdSeq    = field18;
  assign cmdArg    = field20;
endmodule

// File: rtl/ctl_ack_rx_chk.sv
module ctl_ack_rx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rxValid,
  input logic        rxLast,
  input logic        rxErr,
  input logic        ackValid,
  input logic        cmdValid,
  input logic [47:0] peerMac
);
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(ackValid && cmdValid));
  assert_after_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid || cmdValid) |-> $past(rxValid && rxLast && !rxErr));
  assert_single_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);
  assert_single_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
  assert_err_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxLast && rxErr) |=> !(ackValid || cmdValid));
  assert_peer_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(peerMac) |-> $past(cmdValid));
endmodule

bind ctl_ack_rx ctl_ack_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxLast(rxLast), .rxErr(rxErr),
  .ackValid(ackValid), .cmdValid(cmdValid), .peerMac(peerMac)
);

// File: tb/ctl_ack_rx_test.sv
module ctl_ack_rx_test;
  localparam logic [47:0] LOC = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] rxData = '0;
  logic rxValid = 1'b0, rxLast = 1'b0, rxErr = 1'b0;
  logic ackValid, cmdValid;
  logic [15:0] ackRepeat, cmdCode, cmdSeq;
  logic [31:0] ackPacket, ackDelay, cmdArg;
  logic [47:0] peerMac;

  always #2.5 clk = ~clk;

  ctl_ack_rx uut (
    .clk(clk), .rstN(rstN), .localMac(LOC), .rxData(rxData), .rxValid(rxValid),
    .rxLast(rxLast), .rxErr(rxErr), .ackValid(ackValid), .ackRepeat(ackRepeat),
    .ackPacket(ackPacket), .ackDelay(ackDelay), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdSeq(cmdSeq), .cmdArg(cmdArg), .peerMac(peerMac)
  );

  int compared = 0, mismatched = 0;
  string curReq = "R1";
  logic [7:0] fr[$];

  // behavioural reference model
  logic [7:0] q[$];
  logic expAck = 0, expCmd = 0;
  logic [15:0] eCode, e18;
  logic [31:0] e20, e24;
  logic [47:0] eSrc = '0, expPeer = '0;

  function automatic logic [31:0] getBytes(input int lo, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[23:0], q[lo+i]};
    return v;
  endfunction

  always @(posedge clk) begin
    if (expCmd) expPeer = eSrc;
    expAck = 0;
    expCmd = 0;
    if (!rstN) begin
      q.delete();
      expPeer = '0;
    end else if (rxValid) begin
      q.push_back(rxData);
      if (rxLast) begin
        if (!rxErr && q.size() >= 24) begin
          logic [47:0] dst;
          dst = {getBytes(0, 4), getBytes(4, 2)[15:0]};
          if ((dst == LOC || dst == BC) && getBytes(12, 4) == 32'hFADE0100) begin
            eCode = getBytes(16, 2)[15:0];
            e18   = getBytes(18, 2)[15:0];
            e20   = getBytes(20, 4);
            if (eCode == 16'h0003) begin
              if (q.size() >= 28) begin expAck = 1; e24 = getBytes(24, 4); end
            end else begin
              expCmd = 1;
              eSrc = {getBytes(6, 4), getBytes(10, 2)[15:0]};
            end
          end
        end
        q.delete();
      end
    end
  end

  task automatic cmp(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cmp(curReq, "ackValid", 48'(ackValid), 48'(expAck));
    cmp(curReq, "cmdValid", 48'(cmdValid), 48'(expCmd));
    cmp((curReq == "R1") ? "R1" : "R9", "peerMac", peerMac, expPeer);
    if (expAck) begin
      cmp("R2", "ackRepeat", 48'(ackRepeat), 48'(e18));
      cmp("R2", "ackPacket", 48'(ackPacket), 48'(e20));
      cmp("R2", "ackDelay", 48'(ackDelay), 48'(e24));
    end
    if (expCmd) begin
      cmp("R3", "cmdCode", 48'(cmdCode), 48'(eCode));
      cmp("R3", "cmdSeq", 48'(cmdSeq), 48'(e18));
      cmp("R3", "cmdArg", 48'(cmdArg), 48'(e20));
    end
  end

  task automatic build(input logic [47:0] dst, input logic [47:0] src, input logic [31:0] hdr,
                       input logic [15:0] code, input logic [15:0] f18, input logic [31:0] f20,
                       input logic [31:0] f24, input int len, input int padSeed);
    logic [7:0] full[$];
    full.delete();
    for (int i = 0; i < 6; i++) full.push_back(dst[8*(5-i) +: 8]);
    for (int i = 0; i < 6; i++) full.push_back(src[8*(5-i) +: 8]);
    for (int i = 0; i < 4; i++) full.push_back(hdr[8*(3-i) +: 8]);
    for (int i = 0; i < 2; i++) full.push_back(code[8*(1-i) +: 8]);
    for (int i = 0; i < 2; i++) full.push_back(f18[8*(1-i) +: 8]);
    for (int i = 0; i < 4; i++) full.push_back(f20[8*(3-i) +: 8]);
    for (int i = 0; i < 4; i++) full.push_back(f24[8*(3-i) +: 8]);
    while (full.size() < len) full.push_back(8'(full.size() * padSeed + 3));
    fr.delete();
    for (int i = 0; i < len; i++) fr.push_back(full[i]);
  endtask

  task automatic send(input bit err, input bit gaps, input bit idle);
    for (int i = 0; i < fr.size(); i++) begin
      if (gaps && i % 4 == 2) begin
        @(negedge clk);
        rxValid = 0; rxLast = 0; rxErr = 0;
      end
      @(negedge clk);
      rxValid = 1;
      rxData  = fr[i];
      rxLast  = (i == fr.size() - 1);
      rxErr   = err && rxLast;
    end
    if (idle) begin
      @(negedge clk);
      rxValid = 0; rxLast = 0; rxErr = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  localparam logic [31:0] HOK = 32'hFADE0100;
  localparam logic [47:0] SA = 48'hA1A2A3A4A5A6, SB = 48'hB1B2B3B4B5B6, SC = 48'hC1C2C3C4C5C6;

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    curReq = "R1";
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);

    curReq = "R2";
    build(LOC, SB, HOK, 16'h0003, 16'h0102, 32'h11223344, 32'h55667788, 78, 5); send(0, 0, 1);
    build(LOC, SB, HOK, 16'h0003, 16'hFFFE, 32'h80000001, 32'h0000ABCD, 28, 7); send(0, 0, 1);

    curReq = "R3";
    build(LOC, SA, HOK, 16'h0010, 16'h0042, 32'hDEADBEEF, 32'h0, 78, 9); send(0, 0, 1);
    build(LOC, SB, HOK, 16'h0000, 16'h1234, 32'h0BADF00D, 32'h0, 24, 3); send(0, 0, 1);

    curReq = "R4";
    build(BC, SC, HOK, 16'h0003, 16'h0007, 32'h00000010, 32'h00000020, 78, 2); send(0, 0, 1);
    build(48'h021122334456, SC, HOK, 16'h0011, 16'h1, 32'h1, 32'h0, 78, 2); send(0, 0, 1);
    build(48'h0211223344FF, SC, HOK, 16'h0011, 16'h1, 32'h1, 32'h0, 78, 2); send(0, 0, 1);
    build(48'hFF1122334455, SC, HOK, 16'h0003, 16'h1, 32'h1, 32'h1, 78, 2); send(0, 0, 1);

    curReq = "R5";
    build(LOC, SC, 32'hFADF0100, 16'h0011, 16'h2, 32'h2, 32'h0, 78, 4); send(0, 0, 1);
    build(LOC, SC, 32'hFADE0101, 16'h0003, 16'h2, 32'h2, 32'h2, 78, 4); send(0, 0, 1);
    build(LOC, SC, 32'h0100FADE, 16'h0011, 16'h2, 32'h2, 32'h0, 78, 4); send(0, 0, 1);

    curReq = "R6";
    build(LOC, SC, HOK, 16'h0003, 16'h3, 32'h3, 32'h3, 27, 6); send(0, 0, 1);
    build(LOC, SC, HOK, 16'h0021, 16'h3, 32'h3, 32'h0, 23, 6); send(0, 0, 1);
    build(LOC, SC, HOK, 16'h0021, 16'h3, 32'h3, 32'h0, 10, 6); send(0, 0, 1);

    curReq = "R7";
    build(LOC, SC, HOK, 16'h0021, 16'h4, 32'h4, 32'h0, 78, 8); send(1, 0, 1);
    build(LOC, SC, HOK, 16'h0003, 16'h4, 32'h4, 32'h4, 78, 8); send(1, 0, 1);

    curReq = "R8";
    build(LOC, SB, HOK, 16'h0003, 16'h0A0B, 32'hCAFEBABE, 32'h01020304, 78, 11); send(0, 1, 1);
    build(LOC, SA, HOK, 16'h0022, 16'h5555, 32'h76543210, 32'hFFFFFFFF, 150, 13); send(0, 1, 1);
    build(LOC, SB, HOK, 16'h0003, 16'h0A0C, 32'hCAFEBABF, 32'h0, 300, 17); send(0, 0, 1);

    curReq = "R9";
    build(LOC, SA, HOK, 16'h0030, 16'h9, 32'h9, 32'h0, 78, 3); send(0, 0, 1);
    build(LOC, SB, HOK, 16'h0003, 16'h9, 32'h9, 32'h9, 78, 3); send(0, 0, 1);
    build(LOC, SC, HOK, 16'h0030, 16'h9, 32'h9, 32'h0, 78, 3); send(1, 0, 1);
    build(48'h1, SC, HOK, 16'h0030, 16'h9, 32'h9, 32'h0, 78, 3); send(0, 0, 1);
    build(BC, SC, HOK, 16'h0031, 16'hA, 32'hA, 32'h0, 40, 3); send(0, 0, 1);

    curReq = "R10";
    build(LOC, SA, HOK, 16'h0040, 16'h10, 32'h10, 32'h0, 24, 5); send(0, 0, 0);
    build(LOC, SB, HOK, 16'h0003, 16'h11, 32'h11, 32'h11, 28, 5); send(0, 0, 0);
    build(LOC, SC, HOK, 16'h0041, 16'h12, 32'h12, 32'h0, 24, 5); send(0, 0, 0);
    build(LOC, SA, HOK, 16'h0041, 16'h13, 32'h13, 32'h0, 23, 5); send(0, 0, 0);
    build(LOC, SB, HOK, 16'h0003, 16'h14, 32'h14, 32'h14, 30, 5); send(0, 0, 1);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule